// File: doc/BRIEF.md
# Branch, Jump and Skip Next-PC Unit

This unit decides where a processor's program counter goes after a control-flow instruction and how many execute cycles that instruction occupies. It handles four kinds of operation: plain sequential advance, unconditional relative jump, conditional branch on one status-register bit, and skip-if instructions whose condition has already been evaluated elsewhere (register equality, a register bit, or an I/O bit). The caller supplies the current PC, a signed word offset, the 8-bit status register, the index of the bit to test, the wanted polarity, the skip-condition result, and whether the instruction after a skip is two words long.

Every branch condition is the same generic test: pick one status bit and compare it with the wanted polarity. Signed and unsigned comparisons are just particular bit choices. The offset is sign-extended to the PC width, and all PC arithmetic wraps modulo the program memory size. The result is registered, so it appears one clock after the request strobe and then holds until the next request.

Top module: `pcflow_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `res_valid`, `next_pc`, `exec_cycles` and `taken` are all zero.
- R2: Kind code 0 (sequential) yields `next_pc` = PC+1, `exec_cycles` = 1 and `taken` = 0.
- R3: Kind code 1 (relative jump) yields `next_pc` = PC + offset + 1, `exec_cycles` = 2 and `taken` = 1, whatever the other inputs are.
- R4: Kind code 2 (branch) is taken when `status[bit_sel]` equals `pol_set` (1 = branch if set, 0 = branch if clear). A taken branch yields PC + offset + 1 and `exec_cycles` = 2.
- R5: A branch that is not taken yields PC+1 and `exec_cycles` = 1, with `taken` = 0.
- R6: Status bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, with S holding N xor V. Signed greater-or-equal is bit 4 tested clear and signed less-than is bit 4 tested set. Unsigned same-or-higher is bit 0 tested clear and unsigned lower is bit 0 tested set.
- R7: Kind code 3 (skip) with `skip_cond` = 1 yields PC+2 and `exec_cycles` = 2 when `next_two_word` = 0, or PC+3 and `exec_cycles` = 3 when it is 1, with `taken` = 1.
- R8: A skip with `skip_cond` = 0 yields PC+1, `exec_cycles` = 1 and `taken` = 0; `next_two_word` has no effect on it.
- R9: The offset is a two's-complement value sign-extended to the PC width, and every PC sum wraps modulo 2^PC_W.
- R10: `res_valid` is high exactly one cycle after each cycle with `op_valid` high. With `op_valid` low, the next cycle has `res_valid` low and `next_pc`, `exec_cycles` and `taken` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe for one operation |
| op_kind | input | 2 | 0 sequential, 1 relative jump, 2 branch, 3 skip |
| cur_pc | input | PC_W | Current program counter |
| rel_off | input | OFF_W | Signed word offset |
| status | input | FLAG_W | Status register |
| bit_sel | input | SEL_W | Index of the status bit to test |
| pol_set | input | 1 | 1 branch if bit set, 0 branch if bit clear |
| skip_cond | input | 1 | Evaluated skip condition |
| next_two_word | input | 1 | Instruction after the skip is two words long |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| next_pc | output | PC_W | Resulting program counter |
| exec_cycles | output | 2 | Execute cycles of the operation |
| taken | output | 1 | Control flow left the sequential path |

## Verification
The hardest cases to reach from the ports are the wrap corners, where the sum crosses the ends of program memory: a negative offset from a small PC, a three-word skip from the top address, and sequential advance from the last address. The bench places `cur_pc` right at these edges on purpose. It also sweeps all eight status bits under both polarities, using two complementary status patterns and positive and negative offsets, so each bit is seen both taken and not taken. Skips that do not fire are issued with `next_two_word` high, so the bench can see that the flag has no effect in that case.

// File: rtl/pcflow_pkg.sv
package pcflow_pkg;

    typedef enum logic [1:0] {
        FLOW_SEQ    = 2'd0,
        FLOW_JUMP   = 2'd1,
        FLOW_BRANCH = 2'd2,
        FLOW_SKIP   = 2'd3
    } flow_kind_e;

    typedef enum logic [1:0] {
        STEP_ONE   = 2'd0,
        STEP_TWO   = 2'd1,
        STEP_THREE = 2'd2,
        STEP_REL   = 2'd3
    } step_e;

    localparam int CYC_W = 2;

    typedef struct packed {
        logic              taken;
        step_e             step;
        logic [CYC_W-1:0]  cycles;
    } decision_t;

    // Execute cycles for a skip that fires, chosen by the next instruction's length
    function automatic logic [CYC_W-1:0] skip_cycles(input logic two_word);
        return two_word ? 2'd3 : 2'd2;
    endfunction

    function automatic step_e skip_step(input logic two_word);
        return two_word ? STEP_THREE : STEP_TWO;
    endfunction

endpackage

// File: rtl/pcflow_cond_sel.sv
module pcflow_cond_sel #(
    parameter int FLAG_W = 8,
    localparam int SEL_W = $clog2(FLAG_W)
) (
    input  logic [FLAG_W-1:0] status,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              pol_set,
    output logic              hit
);
    logic [FLAG_W-1:0] match;

    // One polarity comparator per status bit, then a single select
    for (genvar i = 0; i < FLAG_W; i++) begin : g_match
        assign match[i] = (status[i] == pol_set);
    end

    assign hit = match[bit_sel];

endmodule

// File: rtl/pcflow_decide.sv
module pcflow_decide
    import pcflow_pkg::*;
(
    input  flow_kind_e kind,
    input  logic       cond_hit,
    input  logic       skip_cond,
    input  logic       next_two_word,
    output decision_t  dec
);
    always_comb begin
        dec.taken  = 1'b0;
        dec.step   = STEP_ONE;
        dec.cycles = 2'd1;
        unique case (kind)
            FLOW_SEQ: begin
                dec.taken  = 1'b0;
                dec.step   = STEP_ONE;
                dec.cycles = 2'd1;
            end
            FLOW_JUMP: begin
                dec.taken  = 1'b1;
                dec.step   = STEP_REL;
                dec.cycles = 2'd2;
            end
            FLOW_BRANCH: begin
                if (cond_hit) begin
                    dec.taken  = 1'b1;
                    dec.step   = STEP_REL;
                    dec.cycles = 2'd2;
                end
            end
            FLOW_SKIP: begin
                if (skip_cond) begin
                    dec.taken  = 1'b1;
                    dec.step   = skip_step(next_two_word);
                    dec.cycles = skip_cycles(next_two_word);
                end
            end
            default: begin
                dec.taken  = 1'b0;
                dec.step   = STEP_ONE;
                dec.cycles = 2'd1;
            end
        endcase
    end

endmodule

// File: rtl/pcflow_target.sv
module pcflow_target
    import pcflow_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int OFF_W = 12
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  logic [OFF_W-1:0] rel_off,
    input  step_e            step,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] off_ext;
    logic [PC_W-1:0] rel_sum;
    logic [PC_W-1:0] inc_amt;

    // Offset brought to PC width: sign-extended, or truncated when wider
    if (OFF_W >= PC_W) begin : g_trunc
        assign off_ext = rel_off[PC_W-1:0];
    end else begin : g_sext
        assign off_ext = {{(PC_W-OFF_W){rel_off[OFF_W-1]}}, rel_off};
    end

    assign rel_sum = cur_pc + off_ext + PC_W'(1);

    always_comb begin
        unique case (step)
            STEP_TWO:   inc_amt = PC_W'(2);
            STEP_THREE: inc_amt = PC_W'(3);
            default:    inc_amt = PC_W'(1);
        endcase
    end

    // Modulo 2^PC_W wrap comes from the fixed result width
    assign target = (step == STEP_REL) ? rel_sum : (cur_pc + inc_amt);

endmodule

// File: rtl/pcflow_unit.sv
module pcflow_unit
    import pcflow_pkg::*;
#(
    parameter int PC_W   = 12,
    parameter int OFF_W  = 12,
    parameter int FLAG_W = 8,
    localparam int SEL_W = $clog2(FLAG_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [OFF_W-1:0]  rel_off,
    input  logic [FLAG_W-1:0] status,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic              pol_set,
    input  logic              skip_cond,
    input  logic              next_two_word,
    output logic              res_valid,
    output logic [PC_W-1:0]   next_pc,
    output logic [CYC_W-1:0]  exec_cycles,
    output logic              taken
);
    flow_kind_e      kind;
    logic            cond_hit;
    decision_t       dec;
    logic [PC_W-1:0] target;

    assign kind = flow_kind_e'(op_kind);

    pcflow_cond_sel #(.FLAG_W(FLAG_W)) cond_i (
        .status  (status),
        .bit_sel (bit_sel),
        .pol_set (pol_set),
        .hit     (cond_hit)
    );

    pcflow_decide decide_i (
        .kind          (kind),
        .cond_hit      (cond_hit),
        .skip_cond     (skip_cond),
        .next_two_word (next_two_word),
        .dec           (dec)
    );

    pcflow_target #(.PC_W(PC_W), .OFF_W(OFF_W)) target_i (
        .cur_pc  (cur_pc),
        .rel_off (rel_off),
        .step    (dec.step),
        .target  (target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            next_pc     <= '0;
            exec_cycles <= '0;
            taken       <= 1'b0;
        end else begin
            res_valid <= op_valid;
            if (op_valid) begin
                next_pc     <= target;
                exec_cycles <= dec.cycles;
                taken       <= dec.taken;
            end
        end
    end

endmodule

// File: rtl/pcflow_unit_chk.sv
module pcflow_unit_chk #(
    parameter int PC_W = 12
) (
    input logic            clk,
    input logic            rst,
    input logic            op_valid,
    input logic [1:0]      op_kind,
    input logic [PC_W-1:0] cur_pc,
    input logic            next_two_word,
    input logic            res_valid,
    input logic [PC_W-1:0] next_pc,
    input logic [1:0]      exec_cycles,
    input logic            taken
);
    localparam logic [PC_W-1:0] ONE = PC_W'(1);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!res_valid && next_pc == '0 && exec_cycles == 2'd0 && !taken));

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);

    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!res_valid && $stable(next_pc) && $stable(exec_cycles) && $stable(taken)));

    a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd0) |=>
            (next_pc == $past(cur_pc) + ONE && exec_cycles == 2'd1 && !taken));

    a_r3_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd1) |=> (taken && exec_cycles == 2'd2));

    a_r4_branch_taken_cycles: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd2) |=> (!taken || exec_cycles == 2'd2));

    a_r5_not_taken_linear: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken) |-> (exec_cycles == 2'd1));

    a_r7_skip_cycles: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd3) |=>
            (!taken || exec_cycles == 2'd2 + {1'b0, $past(next_two_word)}));

    a_r8_skip_idle_step: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 2'd3) |=> (taken || next_pc == $past(cur_pc) + ONE));

endmodule

bind pcflow_unit pcflow_unit_chk #(.PC_W(PC_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .op_kind       (op_kind),
    .cur_pc        (cur_pc),
    .next_two_word (next_two_word),
    .res_valid     (res_valid),
    .next_pc       (next_pc),
    .exec_cycles   (exec_cycles),
    .taken         (taken)
);

// File: tb/pcflow_unit_tb.sv
`timescale 1ns/1ps
module pcflow_unit_tb_top;
    localparam int PC_W  = 12;
    localparam int OFF_W = 12;
    localparam int MOD   = 1 << PC_W;

    logic             clk = 1'b0;
    logic             rst;
    logic             op_valid;
    logic [1:0]       op_kind;
    logic [PC_W-1:0]  cur_pc;
    logic [OFF_W-1:0] rel_off;
    logic [7:0]       status;
    logic [2:0]       bit_sel;
    logic             pol_set, skip_cond, next_two_word;
    logic             res_valid;
    logic [PC_W-1:0]  next_pc;
    logic [1:0]       exec_cycles;
    logic             taken;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    int last_pc = 0, last_cyc = 0, last_tk = 0;

    always #4 clk = ~clk;

    pcflow_unit #(.PC_W(PC_W), .OFF_W(OFF_W), .FLAG_W(8)) dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
        .cur_pc(cur_pc), .rel_off(rel_off), .status(status), .bit_sel(bit_sel),
        .pol_set(pol_set), .skip_cond(skip_cond), .next_two_word(next_two_word),
        .res_valid(res_valid), .next_pc(next_pc), .exec_cycles(exec_cycles), .taken(taken)
    );

    function automatic int wrap(input int v);
        return ((v % MOD) + MOD) % MOD;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Issue one operation, then compare against the behavioural model one edge later
    task automatic run_op(input string req, input int kind, input int pc, input int off,
                          input int st, input int bsel, input int pol,
                          input int sc, input int tw);
        int soff, e_pc, e_cyc, e_tk;
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind[1:0]; cur_pc = pc[PC_W-1:0];
        rel_off = off[OFF_W-1:0]; status = st[7:0]; bit_sel = bsel[2:0];
        pol_set = pol[0]; skip_cond = sc[0]; next_two_word = tw[0];
        soff = (off >= 0) ? off : off; // offsets are passed as signed ints
        case (kind)
            0: begin e_pc = wrap(pc + 1); e_cyc = 1; e_tk = 0; end
            1: begin e_pc = wrap(pc + soff + 1); e_cyc = 2; e_tk = 1; end
            2: if (((st >> bsel) & 1) == pol) begin
                   e_pc = wrap(pc + soff + 1); e_cyc = 2; e_tk = 1;
               end else begin
                   e_pc = wrap(pc + 1); e_cyc = 1; e_tk = 0;
               end
            default: if (sc != 0) begin
                   e_pc = wrap(pc + 2 + tw); e_cyc = 2 + tw; e_tk = 1;
               end else begin
                   e_pc = wrap(pc + 1); e_cyc = 1; e_tk = 0;
               end
        endcase
        @(negedge clk);
        op_valid = 1'b0;
        check(req, "res_valid", int'(res_valid), 1);
        check(req, "next_pc", int'(next_pc), e_pc);
        check(req, "exec_cycles", int'(exec_cycles), e_cyc);
        check(req, "taken", int'(taken), e_tk);
        last_pc = e_pc; last_cyc = e_cyc; last_tk = e_tk;
    endtask

    // One idle cycle with scrambled inputs: outputs must hold (R10)
    task automatic idle_check();
        op_valid = 1'b0; op_kind = 2'd1; cur_pc = 12'h777; rel_off = 12'h123;
        @(negedge clk);
        check("R10", "idle res_valid", int'(res_valid), 0);
        check("R10", "idle next_pc hold", int'(next_pc), last_pc);
        check("R10", "idle cycles hold", int'(exec_cycles), last_cyc);
        check("R10", "idle taken hold", int'(taken), last_tk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_kind = 2'd0; cur_pc = '0; rel_off = '0;
        status = '0; bit_sel = '0; pol_set = 1'b0; skip_cond = 1'b0; next_two_word = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "reset res_valid", int'(res_valid), 0);
        check("R1", "reset next_pc", int'(next_pc), 0);
        check("R1", "reset cycles", int'(exec_cycles), 0);
        check("R1", "reset taken", int'(taken), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "post-reset res_valid", int'(res_valid), 0);

        // R2 sequential
        run_op("R2", 0, 100, 50, 8'hFF, 0, 1, 1, 1);
        run_op("R2", 0, 4094, 0, 0, 0, 0, 0, 0);
        idle_check();
        // R3 jumps, forward and backward, ignoring branch inputs
        run_op("R3", 1, 200, 37, 8'h00, 3, 1, 0, 0);
        run_op("R3", 1, 200, -150, 8'hFF, 5, 0, 1, 1);
        run_op("R3", 1, 0, 2047, 0, 0, 0, 0, 0);
        // R4/R5 sweep: every bit, both polarities, two patterns, two offsets
        for (int b = 0; b < 8; b++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++)
                    for (int o = 0; o < 2; o++)
                        run_op((((((s ? 8'h5A : 8'hA5) >> b) & 1) == p) ? "R4" : "R5"),
                               2, 300 + b * 16, (o ? -7 : 5), (s ? 8'h5A : 8'hA5), b, p, 0, 0);
        idle_check();
        // R6 signed/unsigned compares: N=1,V=0 -> S=1 (less-than); N=1,V=1 -> S=0 (ge)
        run_op("R6", 2, 500, 10, 8'b0001_0100, 4, 1, 0, 0); // lt taken
        run_op("R6", 2, 500, 10, 8'b0001_0100, 4, 0, 0, 0); // ge not taken
        run_op("R6", 2, 500, -10, 8'b0000_1100, 4, 0, 0, 0); // ge taken
        run_op("R6", 2, 500, 10, 8'b0000_0001, 0, 1, 0, 0); // lower taken
        run_op("R6", 2, 500, 10, 8'b0000_0001, 0, 0, 0, 0); // same-or-higher not taken
        // R7 skips
        run_op("R7", 3, 600, 99, 0, 0, 0, 1, 0);
        run_op("R7", 3, 600, 99, 0, 0, 0, 1, 1);
        // R8 skip not firing, two-word flag set must not matter
        run_op("R8", 3, 600, 99, 0, 0, 0, 0, 1);
        run_op("R8", 3, 601, 99, 0, 0, 0, 0, 0);
        idle_check();
        // R9 wrap corners
        run_op("R9", 0, 4095, 0, 0, 0, 0, 0, 0);
        run_op("R9", 1, 2, -5, 0, 0, 0, 0, 0);
        run_op("R9", 3, 4094, 0, 0, 0, 0, 1, 1);
        run_op("R9", 2, 4090, 20, 8'h80, 7, 1, 0, 0);
        run_op("R9", 1, 4095, -2048, 0, 0, 0, 0, 0);
        // R10 back-to-back ops then idle
        run_op("R10", 1, 10, 1, 0, 0, 0, 0, 0);
        run_op("R10", 0, 11, 0, 0, 0, 0, 0, 0);
        idle_check();
        idle_check();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule